// File: doc/BRIEF.md
# GPIO Pin Event Controller

This block watches a port of general-purpose input pins and turns level conditions or edges on each pin into a status flag. Depending on a per-pin mode, that flag drives an interrupt line, a DMA request line, or nothing beyond the flag itself. Two further modes use the pin's level directly as a trigger output and raise no flag. Each pin also carries a channel bit that routes its flag, interrupt, DMA request or trigger to output channel 0 or channel 1. Pin inputs are expected to be synchronous to `clk` already.

Software configures a single pin with a per-pin write that sets both its mode and its channel. Two half-port writes apply one mode to every pin selected by a 16-bit mask, one for pins 0 to 15 and one for pins 16 to 31. Flags are cleared by writing ones for a channel. A flag raised in a DMA mode is also cleared when that channel's transfer-complete acknowledge arrives. Each channel has its own status word, and that word holds the flags of the pins currently routed to it.

Top module: `pin_event_top`

## Requirements
- R1: After reset every pin is in mode 0x0 on channel 0, and all flags, status words, interrupt, DMA request and trigger outputs are 0.
- R2: Modes 0x0, 0x4, 0xD, 0xE and 0xF never set a flag, whatever the pin does.
- R3: Modes 0x1, 0x2 and 0x3 set the flag on a rising, falling or either edge respectively, and drive the DMA request of the pin's channel while the flag is set. The flag is visible after the second rising clock edge that follows the pin change.
- R4: Modes 0x5, 0x6 and 0x7 set the flag on a rising, falling or either edge respectively, and drive neither interrupt nor DMA request.
- R5: Modes 0x9, 0xA and 0xB set the flag on a rising, falling or either edge respectively, and drive the interrupt of the pin's channel while the flag is set.
- R6: Mode 0x8 sets the flag while the pin is 0, and mode 0xC while the pin is 1; both drive the interrupt. A clear issued while the level persists leaves the flag set.
- R7: A clear write for channel c with mask m clears exactly the flags whose bit in m is 1 and whose pin is routed to channel c.
- R8: When an event and a clear hit the same flag in the same cycle, the flag remains set.
- R9: `dmaAck[c]` clears only the flags of pins in modes 0x1 to 0x3 that are routed to channel c. Flags in other modes and on the other channel are kept.
- R10: Mode 0xD drives the trigger output of the pin's channel while the pin is 1, and mode 0xE does so while the pin is 0. The trigger follows the pin one clock edge after the pin changes.
- R11: Channel bit 0 routes a pin to `statusCh0` and to index 0 of the interrupt, DMA and trigger outputs, and bit 1 routes it to `statusCh1` and index 1. A flag always appears in the status word of the channel its pin is routed to at that moment.
- R12: A low-half write sets the mode of each pin k in 0 to 15 that has `globMask[k]` = 1. A high-half write sets the mode of pin 16+k for each k with `globMask[k]` = 1. Pins outside the mask keep their modes and every channel bit is kept. A per-pin write to the same pin in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Synchronised pin levels |
| cfgWrEn | input | 1 | Per-pin configuration write strobe |
| cfgWrPin | input | 5 | Pin index for the per-pin write |
| cfgWrMode | input | 4 | Mode code for the per-pin write |
| cfgWrChan | input | 1 | Channel bit for the per-pin write |
| globLoWrEn | input | 1 | Mode write to masked pins 0..15 |
| globHiWrEn | input | 1 | Mode write to masked pins 16..31 |
| globMode | input | 4 | Mode code for half-port writes |
| globMask | input | 16 | Pin mask for half-port writes |
| clrWrEn | input | 1 | Write-one-to-clear strobe |
| clrChan | input | 1 | Channel the clear applies to |
| clrMask | input | 32 | Flags to clear |
| dmaAck | input | 2 | Per-channel DMA transfer-complete acknowledge |
| statusCh0 | output | 32 | Flags routed to channel 0 |
| statusCh1 | output | 32 | Flags routed to channel 1 |
| irqOut | output | 2 | Per-channel interrupt |
| dmaReq | output | 2 | Per-channel DMA request |
| trigOut | output | 2 | Per-channel trigger output |

## Verification
The properties assume that every input, the pins included, is synchronous and settles once per cycle, so that the edge detector sees a single clean sample each clock. They also assume reset is held for at least one edge, so that the past mode and flag values they read are defined. The level properties assume that an acknowledge or clear never outruns a persisting level. The stimulus respects these assumptions: it drives every input only at the falling edge of the clock, and it holds each pin level for at least two edges before changing it again. It also issues configuration, clear and acknowledge strobes as single-cycle pulses between those edges.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int PIN_COUNT  = 32;
  localparam int HALF_COUNT = PIN_COUNT / 2;
  localparam int PIN_IDX_W  = $clog2(PIN_COUNT);
  localparam int MODE_W     = 4;
  localparam int CHAN_COUNT = 2;

  // mode codes: the values are decoded by software, so they are fixed
  localparam logic [MODE_W-1:0] MD_OFF       = 4'h0;
  localparam logic [MODE_W-1:0] MD_DMA_RISE  = 4'h1;
  localparam logic [MODE_W-1:0] MD_DMA_FALL  = 4'h2;
  localparam logic [MODE_W-1:0] MD_DMA_ANY   = 4'h3;
  localparam logic [MODE_W-1:0] MD_FLAG_RISE = 4'h5;
  localparam logic [MODE_W-1:0] MD_FLAG_FALL = 4'h6;
  localparam logic [MODE_W-1:0] MD_FLAG_ANY  = 4'h7;
  localparam logic [MODE_W-1:0] MD_IRQ_LOW   = 4'h8;
  localparam logic [MODE_W-1:0] MD_IRQ_RISE  = 4'h9;
  localparam logic [MODE_W-1:0] MD_IRQ_FALL  = 4'hA;
  localparam logic [MODE_W-1:0] MD_IRQ_ANY   = 4'hB;
  localparam logic [MODE_W-1:0] MD_IRQ_HIGH  = 4'hC;
  localparam logic [MODE_W-1:0] MD_TRIG_HIGH = 4'hD;
  localparam logic [MODE_W-1:0] MD_TRIG_LOW  = 4'hE;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic [PIN_COUNT-1:0]                  pinWe;
    logic [MODE_W-1:0]                     pinMode;
    logic                                  pinChan;
    logic [PIN_COUNT-1:0]                  globWe;
    logic [MODE_W-1:0]                     globMode;
    logic [CHAN_COUNT-1:0][PIN_COUNT-1:0]  clrMask;
    logic [CHAN_COUNT-1:0]                 ack;
  } strobes_t;

  function automatic logic eventHit(input logic [MODE_W-1:0] mode,
                                    input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      MD_DMA_RISE, MD_FLAG_RISE, MD_IRQ_RISE: return rise;
      MD_DMA_FALL, MD_FLAG_FALL, MD_IRQ_FALL: return fall;
      MD_DMA_ANY,  MD_FLAG_ANY,  MD_IRQ_ANY:  return rise | fall;
      MD_IRQ_LOW:                             return ~cur;
      MD_IRQ_HIGH:                            return cur;
      default:                                return 1'b0;
    endcase
  endfunction

  function automatic logic isDmaMode(input logic [MODE_W-1:0] mode);
    return (mode >= MD_DMA_RISE) && (mode <= MD_DMA_ANY);
  endfunction

  function automatic logic isIrqMode(input logic [MODE_W-1:0] mode);
    return (mode >= MD_IRQ_LOW) && (mode <= MD_IRQ_HIGH);
  endfunction

  function automatic logic trigActive(input logic [MODE_W-1:0] mode, input logic cur);
    return ((mode == MD_TRIG_HIGH) && cur) || ((mode == MD_TRIG_LOW) && !cur);
  endfunction
endpackage

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
(
  input  logic                  cfgWrEn,
  input  logic [PIN_IDX_W-1:0]  cfgWrPin,
  input  logic [MODE_W-1:0]     cfgWrMode,
  input  logic                  cfgWrChan,
  input  logic                  globLoWrEn,
  input  logic                  globHiWrEn,
  input  logic [MODE_W-1:0]     globMode,
  input  logic [HALF_COUNT-1:0] globMask,
  input  logic                  clrWrEn,
  input  logic                  clrChan,
  input  logic [PIN_COUNT-1:0]  clrMask,
  input  logic [CHAN_COUNT-1:0] dmaAck,
  output strobes_t              strb
);
  logic [PIN_COUNT-1:0] pinSel;

  assign pinSel = cfgWrEn ? (PIN_COUNT'(1) << cfgWrPin) : '0;

  always_comb begin
    strb.pinWe    = pinSel;
    strb.pinMode  = cfgWrMode;
    strb.pinChan  = cfgWrChan;
    // high half in the upper bits, low half in the lower bits
    strb.globWe   = {({HALF_COUNT{globHiWrEn}} & globMask),
                     ({HALF_COUNT{globLoWrEn}} & globMask)};
    strb.globMode = globMode;
    strb.ack      = dmaAck;
  end

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_clr
    assign strb.clrMask[c] = (clrWrEn && (clrChan == c[0])) ? clrMask : '0;
  end
endmodule

// File: rtl/pin_event_dp.sv
module pin_event_dp
  import pin_event_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [PIN_COUNT-1:0]              pinIn,
  input  strobes_t                          strb,
  output logic [PIN_COUNT-1:0]              statusCh0,
  output logic [PIN_COUNT-1:0]              statusCh1,
  output logic [CHAN_COUNT-1:0]             irqOut,
  output logic [CHAN_COUNT-1:0]             dmaReq,
  output logic [CHAN_COUNT-1:0]             trigOut,
  output logic [PIN_COUNT-1:0][MODE_W-1:0]  modeVec,
  output logic [PIN_COUNT-1:0]              pinLevel
);
  logic [PIN_COUNT-1:0]             pinQ, pinPrev;
  logic [PIN_COUNT-1:0]             flagQ, flagD;
  logic [PIN_COUNT-1:0]             chanQ, chanD;
  logic [PIN_COUNT-1:0][MODE_W-1:0] modeQ, modeD;
  logic [PIN_COUNT-1:0]             setEv, dmaPin, irqPin, trigPin, clrHit;
  logic [CHAN_COUNT-1:0][PIN_COUNT-1:0] routed;

  assign routed[0] = ~chanQ;
  assign routed[1] = chanQ;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    always_comb begin
      setEv[i]   = eventHit(modeQ[i], pinQ[i], pinPrev[i]);
      dmaPin[i]  = isDmaMode(modeQ[i]);
      irqPin[i]  = isIrqMode(modeQ[i]);
      trigPin[i] = trigActive(modeQ[i], pinQ[i]);
    end

    // per-pin write beats a half-port write to the same pin
    always_comb begin
      if (strb.pinWe[i]) begin
        modeD[i] = strb.pinMode;
        chanD[i] = strb.pinChan;
      end else if (strb.globWe[i]) begin
        modeD[i] = strb.globMode;
        chanD[i] = chanQ[i];
      end else begin
        modeD[i] = modeQ[i];
        chanD[i] = chanQ[i];
      end
    end

    always_comb begin
      clrHit[i] = strb.clrMask[chanQ[i]][i]
                | (strb.ack[chanQ[i]] & dmaPin[i]);
      // a new event outranks any clear in the same cycle
      flagD[i]  = setEv[i] | (flagQ[i] & ~clrHit[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ    <= '0;
      pinPrev <= '0;
      flagQ   <= '0;
      chanQ   <= '0;
      modeQ   <= '0;
    end else begin
      pinQ    <= pinIn;
      pinPrev <= pinQ;
      flagQ   <= flagD;
      chanQ   <= chanD;
      modeQ   <= modeD;
    end
  end

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_chan
    assign irqOut[c]  = |(flagQ & irqPin & routed[c]);
    assign dmaReq[c]  = |(flagQ & dmaPin & routed[c]);
    assign trigOut[c] = |(trigPin & routed[c]);
  end

  assign statusCh0 = flagQ & routed[0];
  assign statusCh1 = flagQ & routed[1];
  assign modeVec   = modeQ;
  assign pinLevel  = pinQ;
endmodule

// File: rtl/pin_event_top.sv
module pin_event_top
  import pin_event_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic                  cfgWrEn,
  input  logic [PIN_IDX_W-1:0]  cfgWrPin,
  input  logic [MODE_W-1:0]     cfgWrMode,
  input  logic                  cfgWrChan,
  input  logic                  globLoWrEn,
  input  logic                  globHiWrEn,
  input  logic [MODE_W-1:0]     globMode,
  input  logic [HALF_COUNT-1:0] globMask,
  input  logic                  clrWrEn,
  input  logic                  clrChan,
  input  logic [PIN_COUNT-1:0]  clrMask,
  input  logic [CHAN_COUNT-1:0] dmaAck,
  output logic [PIN_COUNT-1:0]  statusCh0,
  output logic [PIN_COUNT-1:0]  statusCh1,
  output logic [CHAN_COUNT-1:0] irqOut,
  output logic [CHAN_COUNT-1:0] dmaReq,
  output logic [CHAN_COUNT-1:0] trigOut
);
  strobes_t                         strb;
  logic [PIN_COUNT-1:0][MODE_W-1:0] dpModeVec;
  logic [PIN_COUNT-1:0]             dpPinLevel;

  pin_event_ctrl ctrl (
    .cfgWrEn(cfgWrEn), .cfgWrPin(cfgWrPin), .cfgWrMode(cfgWrMode),
    .cfgWrChan(cfgWrChan), .globLoWrEn(globLoWrEn), .globHiWrEn(globHiWrEn),
    .globMode(globMode), .globMask(globMask), .clrWrEn(clrWrEn),
    .clrChan(clrChan), .clrMask(clrMask), .dmaAck(dmaAck), .strb(strb)
  );

  pin_event_dp dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strb(strb),
    .statusCh0(statusCh0), .statusCh1(statusCh1), .irqOut(irqOut),
    .dmaReq(dmaReq), .trigOut(trigOut), .modeVec(dpModeVec),
    .pinLevel(dpPinLevel)
  );
endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
  import pin_event_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic [PIN_COUNT-1:0][MODE_W-1:0] modeVec,
  input logic [PIN_COUNT-1:0]             pinLevel,
  input logic [PIN_COUNT-1:0]             statusCh0,
  input logic [PIN_COUNT-1:0]             statusCh1,
  input logic [CHAN_COUNT-1:0]            irqOut,
  input logic [CHAN_COUNT-1:0]            dmaReq
);
  logic [PIN_COUNT-1:0] flagVec;
  logic [CHAN_COUNT-1:0][PIN_COUNT-1:0] stat;

  assign flagVec = statusCh0 | statusCh1;
  assign stat    = {statusCh1, statusCh0};

  function automatic logic [PIN_COUNT-1:0] quietMask(
      input logic [PIN_COUNT-1:0][MODE_W-1:0] m);
    logic [PIN_COUNT-1:0] q;
    for (int i = 0; i < PIN_COUNT; i++)
      q[i] = !((m[i] >= MD_DMA_RISE && m[i] <= MD_DMA_ANY) ||
               (m[i] >= MD_FLAG_RISE && m[i] <= MD_IRQ_HIGH));
    return q;
  endfunction

  // R2: a pin in a mode without events never gains a flag
  p_no_spurious_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & ~$past(flagVec) & quietMask($past(modeVec))) == '0));

  // R11: a flag shows in exactly one channel's status word
  p_status_disjoint_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((statusCh0 & statusCh1) == '0));

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_ch
    // R5: an interrupt needs a flag on its channel
    p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> (stat[c] != '0));
    // R3: a DMA request needs a flag on its channel
    p_dma_has_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[c] |-> (stat[c] != '0));
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_lvl
    // R6: a present level forces the flag on the next edge
    p_level_refire_r6: assert property (@(posedge clk) disable iff (!rstN)
      ((modeVec[i] == MD_IRQ_HIGH && pinLevel[i]) ||
       (modeVec[i] == MD_IRQ_LOW && !pinLevel[i])) |=> flagVec[i]);
  end
endmodule

bind pin_event_top pin_event_chk chk (
  .clk(clk), .rstN(rstN), .modeVec(dpModeVec), .pinLevel(dpPinLevel),
  .statusCh0(statusCh0), .statusCh1(statusCh1), .irqOut(irqOut),
  .dmaReq(dmaReq)
);

// File: tb/pin_event_top_test.sv
`timescale 1ns/1ps
module pin_event_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [4:0]  cfgWrPin = '0;
  logic [3:0]  cfgWrMode = '0;
  logic        cfgWrChan = 1'b0;
  logic        globLoWrEn = 1'b0, globHiWrEn = 1'b0;
  logic [3:0]  globMode = '0;
  logic [15:0] globMask = '0;
  logic        clrWrEn = 1'b0, clrChan = 1'b0;
  logic [31:0] clrMask = '0;
  logic [1:0]  dmaAck = '0;
  logic [31:0] statusCh0, statusCh1;
  logic [1:0]  irqOut, dmaReq, trigOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_event_top uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWrEn(cfgWrEn),
    .cfgWrPin(cfgWrPin), .cfgWrMode(cfgWrMode), .cfgWrChan(cfgWrChan),
    .globLoWrEn(globLoWrEn), .globHiWrEn(globHiWrEn), .globMode(globMode),
    .globMask(globMask), .clrWrEn(clrWrEn), .clrChan(clrChan),
    .clrMask(clrMask), .dmaAck(dmaAck), .statusCh0(statusCh0),
    .statusCh1(statusCh1), .irqOut(irqOut), .dmaReq(dmaReq), .trigOut(trigOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int pin, input logic [3:0] mode, input logic chan);
    cfgWrEn = 1'b1; cfgWrPin = pin[4:0]; cfgWrMode = mode; cfgWrChan = chan;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic clearFlags(input logic chan, input logic [31:0] mask);
    clrWrEn = 1'b1; clrChan = chan; clrMask = mask;
    tick();
    clrWrEn = 1'b0; clrMask = '0;
  endtask

  task automatic ackPulse(input logic [1:0] ack);
    dmaAck = ack;
    tick();
    dmaAck = '0;
  endtask

  task automatic restore();
    globLoWrEn = 1'b1; globHiWrEn = 1'b1; globMode = 4'h0; globMask = 16'hFFFF;
    tick();
    globLoWrEn = 1'b0; globHiWrEn = 1'b0; globMask = '0;
    for (int p = 0; p < 32; p++) cfgWrite(p, 4'h0, 1'b0);
    pinIn = '0;
    tick(); tick();
    clearFlags(1'b0, '1);
    clearFlags(1'b1, '1);
  endtask

  task automatic t_reset();
    check("R1 status0", statusCh0, 0);
    check("R1 status1", statusCh1, 0);
    check("R1 outputs", {26'd0, irqOut, dmaReq, trigOut}, 0);
    pinIn[0] = 1'b1; tick(); tick(); pinIn[0] = 1'b0; tick(); tick();
    check("R1 default mode quiet", statusCh0 | statusCh1, 0);
  endtask

  task automatic t_quiet_modes();
    cfgWrite(5, 4'h0, 1'b0);
    cfgWrite(6, 4'h4, 1'b0);
    cfgWrite(7, 4'hF, 1'b1);
    cfgWrite(8, 4'hD, 1'b0);
    pinIn[8:5] = 4'hF; tick(); tick();
    pinIn[8:5] = 4'h0; tick(); tick();
    check("R2 no flag in quiet modes", statusCh0 | statusCh1, 0);
    restore();
  endtask

  task automatic t_dma();
    cfgWrite(1, 4'h1, 1'b0);
    pinIn[1] = 1'b1; tick();
    check("R3 not yet after one edge", statusCh0, 0);
    tick();
    check("R3 rise flag", statusCh0, 32'h2);
    check("R3 dma req ch0", {30'd0, dmaReq}, 2'b01);
    check("R3 no irq", {30'd0, irqOut}, 0);
    ackPulse(2'b01);
    check("R9 ack clears", statusCh0, 0);
    check("R9 dma req drops", {30'd0, dmaReq}, 0);
    cfgWrite(2, 4'h2, 1'b1);
    pinIn[2] = 1'b1; tick(); tick();
    check("R3 falling mode ignores rise", statusCh1, 0);
    pinIn[2] = 1'b0; tick(); tick();
    check("R3 fall flag ch1", statusCh1, 32'h4);
    check("R3 dma req ch1", {30'd0, dmaReq}, 2'b10);
    ackPulse(2'b01);
    check("R9 other channel ack kept", statusCh1, 32'h4);
    ackPulse(2'b10);
    check("R9 own channel ack clears", statusCh1, 0);
    cfgWrite(4, 4'h3, 1'b0);
    pinIn[4] = 1'b1; tick(); tick();
    check("R3 either rise", statusCh0, 32'h10);
    ackPulse(2'b01);
    pinIn[4] = 1'b0; tick(); tick();
    check("R3 either fall", statusCh0, 32'h10);
    ackPulse(2'b01);
    cfgWrite(6, 4'h9, 1'b0);
    pinIn[6] = 1'b1; tick(); tick();
    ackPulse(2'b01);
    check("R9 ack keeps irq-mode flag", statusCh0, 32'h40);
    restore();
  endtask

  task automatic t_flag_only();
    cfgWrite(7, 4'h5, 1'b0);
    cfgWrite(8, 4'h6, 1'b0);
    cfgWrite(9, 4'h7, 1'b1);
    pinIn[9:7] = 3'b111; tick(); tick();
    check("R4 rise flags ch0", statusCh0, 32'h80);
    check("R4 either rise ch1", statusCh1, 32'h200);
    check("R4 no irq or dma", {28'd0, irqOut, dmaReq}, 0);
    clearFlags(1'b1, 32'h200);
    pinIn[9:7] = 3'b000; tick(); tick();
    check("R4 fall flags ch0", statusCh0, 32'h180);
    check("R4 either fall ch1", statusCh1, 32'h200);
    restore();
  endtask

  task automatic t_irq_edge();
    cfgWrite(10, 4'hA, 1'b0);
    cfgWrite(11, 4'hB, 1'b1);
    pinIn[11:10] = 2'b11; tick(); tick();
    check("R5 either-edge irq only", {30'd0, irqOut}, 2'b10);
    check("R5 falling mode idle", statusCh0, 0);
    pinIn[11:10] = 2'b00; tick(); tick();
    check("R5 both irqs", {30'd0, irqOut}, 2'b11);
    check("R5 fall flag", statusCh0, 32'h400);
    check("R5 no dma", {30'd0, dmaReq}, 0);
    restore();
  endtask

  task automatic t_level();
    pinIn[12] = 1'b1; tick();
    cfgWrite(12, 4'hC, 1'b0);
    tick();
    check("R6 high level flag", statusCh0, 32'h1000);
    check("R6 level irq", {30'd0, irqOut}, 2'b01);
    clearFlags(1'b0, 32'h1000);
    check("R6 refires while high", statusCh0, 32'h1000);
    pinIn[12] = 1'b0; tick();
    clearFlags(1'b0, 32'h1000);
    check("R6 clears once level gone", statusCh0, 0);
    cfgWrite(13, 4'h8, 1'b1);
    tick();
    check("R6 low level flag", statusCh1, 32'h2000);
    check("R6 low level irq", {30'd0, irqOut}, 2'b10);
    restore();
  endtask

  task automatic t_w1c();
    cfgWrite(7, 4'h5, 1'b0);
    cfgWrite(9, 4'h5, 1'b0);
    cfgWrite(21, 4'h5, 1'b1);
    pinIn[7] = 1'b1; pinIn[9] = 1'b1; pinIn[21] = 1'b1; tick(); tick();
    clearFlags(1'b1, 32'h80);
    check("R7 wrong channel no effect", statusCh0, 32'h280);
    clearFlags(1'b0, 32'h80);
    check("R7 masked bit cleared", statusCh0, 32'h200);
    check("R7 other channel kept", statusCh1, 32'h200000);
    clearFlags(1'b0, 32'h200000);
    check("R7 ch0 clear ignores ch1 pin", statusCh1, 32'h200000);
    restore();
  endtask

  task automatic t_event_wins();
    cfgWrite(3, 4'h9, 1'b0);
    pinIn[3] = 1'b1; tick(); tick();
    pinIn[3] = 1'b0; tick(); tick();
    check("R8 flag held before", statusCh0, 32'h8);
    pinIn[3] = 1'b1; tick();
    clearFlags(1'b0, 32'h8);
    check("R8 event beats clear", statusCh0, 32'h8);
    clearFlags(1'b0, 32'h8);
    check("R8 plain clear", statusCh0, 0);
    restore();
  endtask

  task automatic t_trigger();
    cfgWrite(14, 4'hD, 1'b1);
    pinIn[14] = 1'b1; tick();
    check("R10 active-high trigger", {30'd0, trigOut}, 2'b10);
    tick();
    check("R10 trigger sets no flag", statusCh0 | statusCh1, 0);
    pinIn[14] = 1'b0; tick();
    check("R10 trigger released", {30'd0, trigOut}, 0);
    cfgWrite(15, 4'hE, 1'b0);
    check("R10 active-low trigger", {30'd0, trigOut}, 2'b01);
    pinIn[15] = 1'b1; tick();
    check("R10 active-low released", {30'd0, trigOut}, 0);
    restore();
  endtask

  task automatic t_routing();
    cfgWrite(20, 4'h5, 1'b1);
    pinIn[20] = 1'b1; tick(); tick();
    check("R11 routed to ch1", statusCh1, 32'h100000);
    check("R11 absent from ch0", statusCh0, 0);
    cfgWrite(20, 4'h5, 1'b0);
    check("R11 follows new routing", statusCh0, 32'h100000);
    check("R11 left ch1", statusCh1, 0);
    restore();
  endtask

  task automatic t_global();
    cfgWrite(0, 4'h1, 1'b0);
    cfgWrite(1, 4'h1, 1'b0);
    cfgWrite(2, 4'h1, 1'b1);
    globLoWrEn = 1'b1; globMode = 4'h5; globMask = 16'h0003;
    tick();
    globLoWrEn = 1'b0;
    pinIn[2:0] = 3'b111; tick(); tick();
    check("R12 low half masked pins", statusCh0, 32'h3);
    check("R12 unmasked keeps mode and chan", statusCh1, 32'h4);
    check("R12 dma only from unmasked", {30'd0, dmaReq}, 2'b10);
    globHiWrEn = 1'b1; globMode = 4'h7; globMask = 16'h0001;
    tick();
    globHiWrEn = 1'b0;
    pinIn[17:16] = 2'b11; tick(); tick();
    check("R12 high half pin 16", statusCh0, 32'h10003);
    pinIn[17] = 1'b0; tick(); tick();
    cfgWrEn = 1'b1; cfgWrPin = 5'd17; cfgWrMode = 4'h5; cfgWrChan = 1'b1;
    globHiWrEn = 1'b1; globMode = 4'h0; globMask = 16'h0002;
    tick();
    cfgWrEn = 1'b0; globHiWrEn = 1'b0;
    pinIn[17] = 1'b1; tick(); tick();
    check("R12 per-pin write wins", statusCh1, 32'h20004);
    restore();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_quiet_modes();
    t_dma();
    t_flag_only();
    t_irq_edge();
    t_level();
    t_w1c();
    t_event_wins();
    t_trigger();
    t_routing();
    t_global();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule